// File: doc/BRIEF.md
# Four-Way Set-Associative Cache Lookup

This block holds the tag, valid and data storage of a set-associative cache and answers lookups against it. A 32-bit byte address is split into a tag, a set index and a byte offset. All ways of the selected set are compared at the same time. One clock after the lookup strobe the block reports whether a way matched and returns that way's data word.

After a miss, the surrounding logic presents the same address with the word fetched from the next memory level on the fill port. The block then writes that word into the set. It uses an empty way when the set has one. Otherwise it replaces the least recently used way. Every hit and every fill makes the touched way the most recent one in its set.

The way count defaults to four and can be lowered to two. Each set keeps its recency as a full age ordering of its ways.

Top module: `set_assoc_lookup`

## Requirements
- R1: After reset every way of every set is empty, so any lookup reports a miss with a data word of zero.
- R2: Address bits [31:10] form the tag, bits [9:2] select one of 256 sets, and bits [1:0] have no effect on lookup or fill.
- R3: `rsp_valid` is high in exactly the cycle after a lookup strobe, and `rsp_hit` can be high only then. A miss returns a data word of zero.
- R4: A hit returns the data word of the one way whose valid bit is set and whose tag matches. At most one way of a set matches.
- R5: A fill writes an empty way while the set still has one, choosing the lowest-numbered empty way, so four fills of distinct tags into one set leave all four present. Exactly one way is chosen per fill.
- R6: With no empty way, a fill replaces the way touched least recently, where a hit and a fill each count as a touch.
- R7: A fill whose tag is already present in the set overwrites that way's data in place and evicts nothing. A filled address hits on the next lookup.
- R8: A lookup strobe in the same cycle as a fill is dropped: no response follows it, and it does not change the recency order.
- R9: With two ways, the block addresses 0, 8, 0, 6, 8 in one set, each miss followed by a fill, give miss, miss, hit, miss, miss.
- R10: With four ways, the same sequence gives miss, miss, hit, miss, hit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lkp_req | input | 1 | Lookup strobe |
| lkp_addr | input | 32 | Lookup byte address |
| fill_req | input | 1 | Fill strobe |
| fill_addr | input | 32 | Byte address of the word being filled |
| fill_data | input | 32 | Word written by the fill |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Lookup matched a valid way |
| rsp_data | output | 32 | Word from the matching way; zero on a miss |

## Verification
Several lookup patterns are used, and each one separates a different fault.

- Lookups that differ only in the offset bits, only in the tag, or only in the set index show whether the address is split at the right bit positions.
- Four fills into one set, followed by a hit on the oldest way and a fifth fill, separate true least-recently-used replacement from FIFO order or a fixed way choice.
- Refilling a tag that is already present shows whether the block overwrites in place or creates a duplicate.
- A lookup issued together with a fill shows whether the dropped request leaks a response.
- The block sequence 0, 8, 0, 6, 8 is run on both a two-way and a four-way instance. Its last access must miss with two ways and hit with four, which ties the replacement outcome to the way count.

// File: rtl/set_assoc_lookup.sv
module set_assoc_lookup #(
  parameter int WAYS   = 4,
  parameter int SETS   = 256,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFS_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lkp_req,
  input  logic [ADDR_W-1:0] lkp_addr,
  input  logic              fill_req,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [DATA_W-1:0] fill_data,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_data
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W - OFS_W;
  localparam int AGE_W = $clog2(WAYS);
  localparam logic [AGE_W-1:0] OLDEST = AGE_W'(WAYS - 1);

  logic [WAYS-1:0]   vld_q [SETS];
  logic [TAG_W-1:0]  tag_q [SETS][WAYS];
  logic [DATA_W-1:0] dat_q [SETS][WAYS];
  logic [AGE_W-1:0]  age_q [SETS][WAYS];

  logic [IDX_W-1:0] l_idx, f_idx, t_idx;
  logic [TAG_W-1:0] l_tag, f_tag;
  logic [WAYS-1:0]  l_match, f_match, victim_oh, fill_oh, t_oh;
  logic [DATA_W-1:0] l_data;
  logic [AGE_W-1:0] t_age;
  logic do_lkp;
  logic unused_ofs;

  assign l_idx = lkp_addr[OFS_W +: IDX_W];
  assign l_tag = lkp_addr[ADDR_W-1 -: TAG_W];
  assign f_idx = fill_addr[OFS_W +: IDX_W];
  assign f_tag = fill_addr[ADDR_W-1 -: TAG_W];
  assign unused_ofs = ^{lkp_addr[OFS_W-1:0], fill_addr[OFS_W-1:0]};

  assign do_lkp = lkp_req & ~fill_req;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign l_match[w] = vld_q[l_idx][w] && (tag_q[l_idx][w] == l_tag);
    assign f_match[w] = vld_q[f_idx][w] && (tag_q[f_idx][w] == f_tag);
  end

  always_comb begin
    l_data = '0;
    for (int w = 0; w < WAYS; w++)
      if (l_match[w]) l_data = l_data | dat_q[l_idx][w];
  end

  always_comb begin
    logic found;
    found = 1'b0;
    victim_oh = '0;
    for (int w = 0; w < WAYS; w++)
      if (!vld_q[f_idx][w] && !found) begin
        victim_oh[w] = 1'b1;
        found = 1'b1;
      end
    if (!found)
      for (int w = 0; w < WAYS; w++)
        if (age_q[f_idx][w] == OLDEST) victim_oh[w] = 1'b1;
  end

  assign fill_oh = (|f_match) ? f_match : victim_oh;
  assign t_idx   = fill_req ? f_idx : l_idx;
  assign t_oh    = fill_req ? fill_oh : (do_lkp ? l_match : '0);

  always_comb begin
    t_age = '0;
    for (int w = 0; w < WAYS; w++)
      if (t_oh[w]) t_age = t_age | age_q[t_idx][w];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_data  <= '0;
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= AGE_W'(w);
      end
    end else begin
      rsp_valid <= do_lkp;
      rsp_hit   <= do_lkp & (|l_match);
      if (do_lkp) rsp_data <= l_data;
      if (fill_req) vld_q[f_idx] <= vld_q[f_idx] | fill_oh;
      if (|t_oh)
        for (int w = 0; w < WAYS; w++) begin
          if (t_oh[w]) age_q[t_idx][w] <= '0;
          else if (age_q[t_idx][w] < t_age) age_q[t_idx][w] <= age_q[t_idx][w] + 1'b1;
        end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_req)
      for (int w = 0; w < WAYS; w++)
        if (fill_oh[w]) begin
          tag_q[f_idx][w] <= f_tag;
          dat_q[f_idx][w] <= fill_data;
        end
  end

  a_r4_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_req |-> $onehot0(l_match));

  a_r5_one_victim: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |-> $onehot(fill_oh));

  a_r3_hit_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);

  a_r7_fill_visible: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fill_req) && do_lkp &&
     lkp_addr[ADDR_W-1:OFS_W] == $past(fill_addr[ADDR_W-1:OFS_W])) |=> rsp_hit);
endmodule

// File: tb/set_assoc_lookup_bench.sv
module set_assoc_lookup_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel2 = 1'b0;
  logic lkp = 1'b0, fil = 1'b0;
  logic [31:0] la = '0, fa = '0, fd = '0;
  logic v4, h4, v2, h2;
  logic [31:0] d4, d2;
  logic rv, rh;
  logic [31:0] rd;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  set_assoc_lookup u_set_assoc_lookup (
    .clk(clk), .rst_n(rst_n), .lkp_req(lkp & ~sel2), .lkp_addr(la),
    .fill_req(fil & ~sel2), .fill_addr(fa), .fill_data(fd),
    .rsp_valid(v4), .rsp_hit(h4), .rsp_data(d4));

  set_assoc_lookup #(.WAYS(2)) u_set_assoc_lookup_w2 (
    .clk(clk), .rst_n(rst_n), .lkp_req(lkp & sel2), .lkp_addr(la),
    .fill_req(fil & sel2), .fill_addr(fa), .fill_data(fd),
    .rsp_valid(v2), .rsp_hit(h2), .rsp_data(d2));

  assign rv = sel2 ? v2 : v4;
  assign rh = sel2 ? h2 : h4;
  assign rd = sel2 ? d2 : d4;

  function automatic logic [31:0] mk(input logic [21:0] t, input logic [7:0] s, input logic [1:0] o);
    return {t, s, o};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic look(input logic [31:0] a, input bit eh, input logic [31:0] ed, input string req);
    @(negedge clk); lkp = 1'b1; la = a;
    @(negedge clk); lkp = 1'b0;
    chk(rv === 1'b1, {req, " valid"}, 32'(rv), 32'd1);
    chk(rh === eh, {req, " hit"}, 32'(rh), 32'(eh));
    if (eh) chk(rd === ed, {req, " data"}, rd, ed);
    else    chk(rd === 32'd0, {req, " miss data"}, rd, 32'd0);
  endtask

  task automatic fill(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); fil = 1'b1; fa = a; fd = d;
    @(negedge clk); fil = 1'b0;
  endtask

  task automatic t_reset;
    chk(rv === 1'b0, "R3 idle after reset", 32'(rv), 32'd0);
    look(mk(22'h0, 8'h0, 2'b00), 1'b0, 0, "R1 empty set0");
    look(mk(22'h3FFFFF, 8'hFF, 2'b11), 1'b0, 0, "R1 empty set255");
  endtask

  task automatic t_fields;
    fill(mk(22'h3A5, 8'd5, 2'b00), 32'hCAFE_0001);
    look(mk(22'h3A5, 8'd5, 2'b11), 1'b1, 32'hCAFE_0001, "R2 offset ignored");
    look(mk(22'h3A4, 8'd5, 2'b00), 1'b0, 0, "R2 tag differs");
    look(mk(22'h3A5, 8'd6, 2'b00), 1'b0, 0, "R2 index differs");
    look(mk(22'h3A5, 8'd5, 2'b01), 1'b1, 32'hCAFE_0001, "R4 hit data");
    @(negedge clk);
    chk(rv === 1'b0, "R3 single-cycle valid", 32'(rv), 32'd0);
  endtask

  task automatic t_lru;
    for (int i = 0; i < 4; i++) fill(mk(22'(i + 1), 8'd20, 2'b00), 32'h100 + i);
    for (int i = 0; i < 4; i++) look(mk(22'(i + 1), 8'd20, 2'b00), 1'b1, 32'h100 + i, "R5 four ways kept");
    look(mk(22'd1, 8'd20, 2'b00), 1'b1, 32'h100, "R6 touch oldest");
    fill(mk(22'd9, 8'd20, 2'b00), 32'h999);
    look(mk(22'd2, 8'd20, 2'b00), 1'b0, 0, "R6 lru evicted");
    look(mk(22'd1, 8'd20, 2'b00), 1'b1, 32'h100, "R6 touched kept");
    look(mk(22'd3, 8'd20, 2'b00), 1'b1, 32'h102, "R6 kept");
    look(mk(22'd4, 8'd20, 2'b00), 1'b1, 32'h103, "R6 kept");
    look(mk(22'd9, 8'd20, 2'b00), 1'b1, 32'h999, "R6 new entry");
  endtask

  task automatic t_refill;
    fill(mk(22'd7, 8'd30, 2'b00), 32'hA1);
    fill(mk(22'd8, 8'd30, 2'b00), 32'hB2);
    fill(mk(22'd7, 8'd30, 2'b10), 32'hA3);
    look(mk(22'd7, 8'd30, 2'b00), 1'b1, 32'hA3, "R7 overwritten");
    look(mk(22'd8, 8'd30, 2'b00), 1'b1, 32'hB2, "R7 other kept");
  endtask

  task automatic t_collide;
    @(negedge clk); fil = 1'b1; fa = mk(22'd5, 8'd40, 2'b00); fd = 32'h55;
    lkp = 1'b1; la = mk(22'h3A5, 8'd5, 2'b00);
    @(negedge clk); fil = 1'b0; lkp = 1'b0;
    chk(rv === 1'b0, "R8 no response", 32'(rv), 32'd0);
    look(mk(22'd5, 8'd40, 2'b00), 1'b1, 32'h55, "R8 fill done");
  endtask

  task automatic t_seq(input bit two, input logic [4:0] exp, input string req);
    int blk[5] = '{0, 8, 0, 6, 8};
    sel2 = two;
    for (int i = 0; i < 5; i++) begin
      logic [31:0] a;
      a = mk(22'(blk[i]), 8'd7, 2'b00);
      look(a, exp[i], 32'h700 + blk[i], req);
      if (!exp[i]) fill(a, 32'h700 + blk[i]);
    end
    sel2 = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fields();
    t_lru();
    t_refill();
    t_collide();
    t_seq(1'b1, 5'b00100, "R9 two-way sequence");
    t_seq(1'b0, 5'b10100, "R10 four-way sequence");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule